// File: doc/BRIEF.md
# Receive Data and Error Status Register

This block sits between the receive shifter of a processor-attached asynchronous serial adapter and the processor bus. Each time the shifter finishes a character, it presents the character together with two checks: whether the stop bit was good and whether the parity matched. The block decides whether the character may enter the receive data register. If it does, the block captures the framing and parity results of that character as status flags.

If a finished character arrives while the data register still holds a word the processor has not read, the new character is dropped. The older word stays readable. The drop is noted internally. The overrun flag becomes visible only on the processor's next read of the data register, and the read after that clears it. An active-low reset and a master-reset command from the control register both clear all flags. The interrupt-request level comes from outside the block. It is mirrored into the status byte and driven out on an active-low pin.

Top module: `rxs_status_top`

## Requirements
- R1: While or after `rst_n` is low, `rx_data` is 0, `status` is 0x00 apart from bit 7, and no flag is set until a character is loaded.
- R2: A `chr_done` strobe while status bit 0 (data full) is clear loads `chr_data` into `rx_data` and sets status bit 0 after the same clock edge.
- R3: Status bit 4 (framing error) takes the inverse of `stop_ok` of each loaded character. It keeps its value across reads and across dropped characters until the next load.
- R4: Status bit 6 (parity error) is set when a character with `parity_en`=1 and `parity_ok`=0 is loaded. A data-register read clears it.
- R5: When a character is loaded with `parity_en`=0, status bit 6 is cleared, whatever `parity_ok` is.
- R6: A `chr_done` without `rd_stb` while status bit 0 is set leaves `rx_data` and status bit 0 unchanged, and the new character is lost.
- R7: After a dropped character, the next read keeps the older word on `rx_data` and sets status bit 5 (overrun). The following read clears bit 5 unless another drop came in between.
- R8: `mreset` clears status bits 0, 4, 5 and 6 and any pending overrun on the next edge. It takes priority over a load or read in the same cycle.
- R9: When `rd_stb` and `chr_done` fall in the same cycle, the read acts first. The new character is loaded, status bit 0 stays set, and no overrun is recorded.
- R10: Status bit 7 equals `irq_req` and `irq_n` equals its inverse, with no clock delay.
- R11: A read with no load clears status bit 0. Status bits 1 to 3 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mreset | input | 1 | Master-reset command from the control register |
| chr_done | input | 1 | One-cycle strobe: the shifter has a complete character |
| chr_data | input | DATA_W | Assembled character |
| stop_ok | input | 1 | Stop bit of the character was valid |
| parity_ok | input | 1 | Received parity matched the computed parity |
| parity_en | input | 1 | Parity checking is enabled |
| rd_stb | input | 1 | One-cycle processor read of the data register |
| irq_req | input | 1 | Interrupt-request level from the interrupt logic |
| rx_data | output | DATA_W | Receive data register |
| status | output | 8 | Bit 0 full, 4 framing, 5 overrun, 6 parity, 7 interrupt |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
The bench uses the defaults: an 8-bit character and a two-stage reset synchronizer. The 8-bit data path allows distinct patterns, so a dropped character can be told apart from the word that was kept. The two synchronizer stages let the bench check that reset asserts asynchronously, in the middle of a cycle, while release waits for clock edges. The vector table runs through chains of drops, same-cycle read and load, and disabled parity.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int STAT_W   = 8;
  localparam int FULL_BIT = 0;
  localparam int FE_BIT   = 4;
  localparam int OVR_BIT  = 5;
  localparam int PE_BIT   = 6;
  localparam int IRQ_BIT  = 7;

  typedef struct packed {
    logic fe;
    logic pe;
  } rxs_err_t;
endpackage

// File: rtl/rxs_data_reg.sv
module rxs_data_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              ld,
  input  logic              rd,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              full,
  output logic              accept,
  output logic              overrun
);
  logic [DATA_W-1:0] data_q;
  logic              full_q, full_d, data_en;

  always_comb begin
    overrun = ld && full_q && !rd;
    accept  = ld && !overrun;
    data_en = accept && !mrst;
    if (mrst)        full_d = 1'b0;
    else if (accept) full_d = 1'b1;
    else if (rd)     full_d = 1'b0;
    else             full_d = full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
      if (data_en) data_q <= din;
    end
  end

  assign dout = data_q;
  assign full = full_q;

  a_r2_load_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mrst) |=> (full_q && data_q == $past(din)));
  a_r6_hold_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> $stable(data_q));
  a_r11_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !ld) |=> !full_q);
endmodule

// File: rtl/rxs_err_flags.sv
module rxs_err_flags
  import rxs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mrst,
  input  logic     accept,
  input  logic     rd,
  input  logic     stop_ok,
  input  logic     parity_ok,
  input  logic     parity_en,
  output rxs_err_t err
);
  rxs_err_t err_q, err_d;

  always_comb begin
    err_d = err_q;
    if (mrst) begin
      err_d = '0;
    end else if (accept) begin
      err_d.fe = !stop_ok;
      err_d.pe = parity_en && !parity_ok;
    end else if (rd) begin
      err_d.pe = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_d;
  end

  assign err = err_q;

  a_r3_fe_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !mrst) |=> $stable(err_q.fe));
  a_r4_pe_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !accept) |=> !err_q.pe);
  a_r5_no_pe_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !parity_en) |=> !err_q.pe);
endmodule

// File: rtl/rxs_ovr_track.sv
module rxs_ovr_track (
  input  logic clk,
  input  logic rst_n,
  input  logic mrst,
  input  logic overrun,
  input  logic rd,
  output logic ovr
);
  logic pend_q, pend_d, ovr_q, ovr_d;

  always_comb begin
    if (mrst)         pend_d = 1'b0;
    else if (overrun) pend_d = 1'b1;
    else if (rd)      pend_d = 1'b0;
    else              pend_d = pend_q;
    if (mrst)         ovr_d = 1'b0;
    else if (rd)      ovr_d = pend_q;
    else              ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
    end
  end

  assign ovr = ovr_q;

  a_r7_ovr_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && pend_q && !mrst) |=> ovr_q);
  a_r7_ovr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !pend_q) |=> !ovr_q);
  a_r8_mreset_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    mrst |=> (!ovr_q && !pend_q));
endmodule

// File: rtl/rxs_status_top.sv
module rxs_status_top
  import rxs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mreset,
  input  logic              chr_done,
  input  logic [DATA_W-1:0] chr_data,
  input  logic              stop_ok,
  input  logic              parity_ok,
  input  logic              parity_en,
  input  logic              rd_stb,
  input  logic              irq_req,
  output logic [DATA_W-1:0] rx_data,
  output logic [7:0]        status,
  output logic              irq_n
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] sync_q;
  logic              rst_int_n;
  logic              full, accept, overrun, ovr;
  rxs_err_t          err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_MSB:0] , 1'b1} >> 0;
  end
  assign rst_int_n = sync_q[SYNC_MSB];

  rxs_data_reg #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_int_n), .mrst(mreset), .ld(chr_done), .rd(rd_stb),
    .din(chr_data), .dout(rx_data), .full(full), .accept(accept),
    .overrun(overrun)
  );

  rxs_err_flags u_err (
    .clk(clk), .rst_n(rst_int_n), .mrst(mreset), .accept(accept), .rd(rd_stb),
    .stop_ok(stop_ok), .parity_ok(parity_ok), .parity_en(parity_en), .err(err)
  );

  rxs_ovr_track u_ovr (
    .clk(clk), .rst_n(rst_int_n), .mrst(mreset), .overrun(overrun),
    .rd(rd_stb), .ovr(ovr)
  );

  always_comb begin
    status           = '0;
    status[FULL_BIT] = full;
    status[FE_BIT]   = err.fe;
    status[OVR_BIT]  = ovr;
    status[PE_BIT]   = err.pe;
    status[IRQ_BIT]  = irq_req;
    irq_n            = !irq_req;
  end

  a_r9_read_and_load: assert property (@(posedge clk) disable iff (!rst_int_n)
    (chr_done && rd_stb && !mreset) |=> status[FULL_BIT]);
  a_r8_mreset_clears: assert property (@(posedge clk) disable iff (!rst_int_n)
    mreset |=> (status[6:4] == 3'b000 && !status[FULL_BIT]));
  a_r11_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    status[3:1] == 3'b000);
endmodule

// File: tb/rxs_status_top_bench.sv
module rxs_status_top_bench;
  localparam int DW = 8;
  localparam int NV = 14;
  // {ld, rd, stop_ok, parity_ok, parity_en, din, exp_data, exp_status}
  localparam logic [28:0] VEC [NV] = '{
    {5'b10111, 8'hA5, 8'hA5, 8'h01},  // R2 load into empty
    {5'b10111, 8'h3C, 8'hA5, 8'h01},  // R6 dropped
    {5'b01000, 8'h00, 8'hA5, 8'h20},  // R7 overrun shows on read
    {5'b01000, 8'h00, 8'hA5, 8'h00},  // R7 next read clears
    {5'b10001, 8'h5A, 8'h5A, 8'h51},  // R3 R4 framing and parity
    {5'b01000, 8'h00, 8'h5A, 8'h10},  // R4 R11 read keeps fe
    {5'b10100, 8'hC3, 8'hC3, 8'h01},  // R5 parity disabled
    {5'b11101, 8'h77, 8'h77, 8'h41},  // R9 read and load
    {5'b01000, 8'h00, 8'h77, 8'h00},  // R11 read
    {5'b10010, 8'h11, 8'h11, 8'h11},  // R3 framing, parity off
    {5'b10111, 8'h22, 8'h11, 8'h11},  // R6 drop keeps fe
    {5'b10111, 8'h33, 8'h11, 8'h11},  // R6 second drop
    {5'b11111, 8'h44, 8'h44, 8'h21},  // R9 R7 read+load with pending
    {5'b01000, 8'h00, 8'h44, 8'h00}   // R7 ovr cleared
  };

  logic clk = 1'b0;
  logic rst_n, mreset, chr_done, stop_ok, parity_ok, parity_en, rd_stb, irq_req;
  logic [DW-1:0] chr_data, rx_data;
  logic [7:0] status;
  logic irq_n;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rxs_status_top u_rxs_status_top (
    .clk(clk), .rst_n(rst_n), .mreset(mreset), .chr_done(chr_done),
    .chr_data(chr_data), .stop_ok(stop_ok), .parity_ok(parity_ok),
    .parity_en(parity_en), .rd_stb(rd_stb), .irq_req(irq_req),
    .rx_data(rx_data), .status(status), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cycle(input logic ld, input logic rd, input logic so, input logic po,
                       input logic pe, input logic [DW-1:0] d, input logic mr);
    chr_done = ld; rd_stb = rd; stop_ok = so; parity_ok = po; parity_en = pe;
    chr_data = d; mreset = mr;
    @(posedge clk); #1;
    chr_done = 0; rd_stb = 0; mreset = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    #1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 0; mreset = 0; chr_done = 0; stop_ok = 1; parity_ok = 1;
    parity_en = 0; rd_stb = 0; irq_req = 0; chr_data = '0;
    do_reset();
    check("R1 data", rx_data, 0);
    check("R1 status", status, 8'h00);
    check("R1 irq_n", irq_n, 1);

    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i][28], VEC[i][27], VEC[i][26], VEC[i][25], VEC[i][24],
            VEC[i][23:16], 1'b0);
      check($sformatf("R2-vector %0d data", i), rx_data, VEC[i][15:8]);
      check($sformatf("R3R4R6R7 vector %0d status", i), status, VEC[i][7:0]);
    end

    // R10 interrupt mirror, no clock delay
    irq_req = 1; #1;
    check("R10 status bit7", status[7], 1);
    check("R10 irq_n", irq_n, 0);
    irq_req = 0; #1;
    check("R10 irq_n release", irq_n, 1);

    // R8 master reset clears flags and pending overrun
    cycle(1, 0, 0, 0, 1, 8'h9E, 0);
    check("R3 fe+pe load", status, 8'h51);
    cycle(1, 0, 1, 1, 1, 8'h01, 0);   // dropped, pending overrun
    cycle(0, 0, 1, 1, 1, 8'h00, 1);   // master reset
    check("R8 status after mreset", status, 8'h00);
    cycle(0, 1, 1, 1, 1, 8'h00, 0);
    check("R8 pending cleared", status, 8'h00);
    cycle(1, 1, 1, 1, 1, 8'h66, 1);   // mreset wins over load
    check("R8 priority", status, 8'h00);

    // R1 asynchronous reset mid-cycle
    cycle(1, 0, 0, 1, 0, 8'hF0, 0);
    check("R2 load before reset", rx_data, 8'hF0);
    #1 rst_n = 0; #1;
    check("R1 async data", rx_data, 0);
    check("R1 async status", status, 8'h00);
    do_reset();
    check("R1 after release", status, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule